// File: doc/BRIEF.md
# Broadcast Storm Limiter

This block sits beside one ingress port of a switch. It decides, frame by frame, whether a broadcast frame is passed on or discarded. It watches a start strobe and a broadcast flag for each accepted frame. It keeps a count of how many broadcast frames have arrived back to back. Once that count reaches a limit, further broadcast frames in the same run are dropped. The run ends in two ways: any non-broadcast frame ends it, and so does the close of a fixed time window. The window is built by counting a slow periodic tick; with a 1 ms tick and 800 ticks per window it lasts 800 ms. The bench shortens the window through a parameter.

The limiter is turned on or off by a strap input that is sampled only while reset is asserted. A strap value of 1 switches the limiter off. A saturating counter of dropped frames is presented on an output. Address decoding and frame storage belong to other blocks.

Control is a three-state machine. The states are:
- `ST_BYPASS`: the limiter is off, the run count is held at zero and nothing is dropped.
- `ST_COUNT`: the run is below the limit.
- `ST_CLAMP`: the run has reached the limit.

The transitions are:
- T_ENABLE: `ST_BYPASS` to `ST_COUNT`, in the first cycle after reset when the sampled strap enables the limiter.
- T_ARM: `ST_COUNT` to `ST_CLAMP`, when the counted broadcast frame brings the run to the limit.
- T_RELEASE: `ST_CLAMP` to `ST_COUNT`, at a window close or a non-broadcast frame.

Every other case holds the state.

Top module: `bcast_storm_limiter`

## Requirements
- R1: While enabled, broadcast frames 1 to LIMIT (default 64) of an unbroken run pass (`verdict_drop`=0); each decision uses the run count before the frame is counted.
- R2: While enabled, every broadcast frame after the LIMIT-th of an unbroken run is dropped; the run count saturates at LIMIT and does not wrap.
- R3: A non-broadcast frame is never dropped and resets the run count to zero, so the next LIMIT broadcast frames pass.
- R4: After TICKS_PER_WINDOW ticks (counted since reset or the previous window close), the run count returns to zero; one tick fewer does not clear it. A broadcast frame that arrives in the same cycle as the closing tick is treated as the first frame of a new run and passes.
- R5: `verdict_valid` is a one-cycle pulse in the clock cycle after the cycle in which `frame_start` is 1, and `verdict_drop` is valid in that cycle. Without `frame_start`, both stay 0.
- R6: If `storm_off_strap` is 1 during reset, no frame is ever dropped and `drop_count` stays 0.
- R7: Changes on `storm_off_strap` after reset release have no effect until the next reset.
- R8: `drop_count` rises by one in the same cycle as each drop verdict, saturates at 2^DROP_W-1, and is cleared only by reset.
- R9: While reset is asserted and after its release, `verdict_valid`, `verdict_drop` and `drop_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| storm_off_strap | input | 1 | Sampled during reset; 1 turns the limiter off |
| win_tick | input | 1 | Periodic tick, one cycle wide, that forms the time window |
| frame_start | input | 1 | One-cycle strobe, one per accepted frame |
| frame_bcast | input | 1 | Marks the frame as broadcast; sampled with `frame_start` |
| verdict_valid | output | 1 | Pulse that marks a decision |
| verdict_drop | output | 1 | 1 = the frame is dropped |
| drop_count | output | DROP_W | Saturating count of dropped frames |

## Verification
Every result appears one clock edge after its stimulus:
- A frame strobe presented in cycle N gives `verdict_valid`, `verdict_drop` and the updated `drop_count` in cycle N+1.
- A closing tick in cycle N clears the run count at that same edge, so it already governs a frame presented in cycle N.

Each bench task drives its inputs on a falling edge and reads the outputs on the next falling edge, exactly one rising edge later. Expected verdicts come from a run-count and window model in the bench that follows the requirements.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_COUNT  = 2'd1,
        ST_CLAMP  = 2'd2
    } bsl_state_e;

endpackage

// File: rtl/bsl_window_timer.sv
module bsl_window_timer #(
    parameter int TICKS_PER_WINDOW = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic win_close
);
    localparam int WIN_W = $clog2(TICKS_PER_WINDOW + 1);
    localparam logic [WIN_W-1:0] LAST_TICK = WIN_W'(TICKS_PER_WINDOW - 1);

    logic [WIN_W-1:0] tick_cnt_q;

    assign win_close = tick && (tick_cnt_q == LAST_TICK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
        end else if (tick) begin
            if (tick_cnt_q == LAST_TICK) tick_cnt_q <= '0;
            else                         tick_cnt_q <= tick_cnt_q + 1'b1;
        end
    end

    // R4: the window count never runs past its last tick
    p_window_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_cnt_q <= LAST_TICK);

endmodule

// File: rtl/bsl_run_tracker.sv
module bsl_run_tracker
    import bsl_pkg::*;
#(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic frame_start,
    input  logic frame_bcast,
    input  logic win_close,
    output logic drop_now,
    output logic verdict_valid,
    output logic verdict_drop
);
    localparam int RUN_W = $clog2(LIMIT + 1);
    localparam logic [RUN_W-1:0] LIMIT_V = RUN_W'(LIMIT);

    bsl_state_e       state_q, state_d;
    logic [RUN_W-1:0] run_q, run_d;
    logic             bcast_seen;

    assign bcast_seen = frame_start && frame_bcast;

    // run-length update: a window close wins over the old count
    always_comb begin
        run_d = run_q;
        unique case (state_q)
            ST_BYPASS: run_d = '0;
            default: begin
                if (win_close)
                    run_d = bcast_seen ? RUN_W'(1) : '0;
                else if (frame_start)
                    run_d = frame_bcast ? ((run_q == LIMIT_V) ? LIMIT_V : run_q + 1'b1) : '0;
            end
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: if (enable)           state_d = ST_COUNT;  // T_ENABLE
            ST_COUNT:  if (run_d == LIMIT_V) state_d = ST_CLAMP;  // T_ARM
            ST_CLAMP:  if (run_d != LIMIT_V) state_d = ST_COUNT;  // T_RELEASE
            default:                         state_d = ST_BYPASS;
        endcase
    end

    assign drop_now = (state_q == ST_CLAMP) && bcast_seen && !win_close;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            verdict_drop  <= 1'b0;
        end else begin
            verdict_valid <= frame_start;
            verdict_drop  <= drop_now;
        end
    end

    p_pass_below_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BYPASS && bcast_seen && !win_close && run_q < LIMIT_V) |=> !verdict_drop);

    p_drop_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_BYPASS && bcast_seen && !win_close && run_q == LIMIT_V) |=> verdict_drop);

    p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LIMIT_V);

    p_other_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !frame_bcast) |=> (run_q == '0 && !verdict_drop));

    p_window_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_close && !bcast_seen) |=> run_q == '0);

    p_verdict_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> verdict_valid);

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (!verdict_valid && !verdict_drop));

endmodule

// File: rtl/bsl_drop_tally.sv
module bsl_drop_tally #(
    parameter int DROP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop_now,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [DROP_W-1:0] TALLY_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                                drop_count <= '0;
        else if (drop_now && drop_count != TALLY_MAX) drop_count <= drop_count + 1'b1;
    end

    p_tally_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_now && drop_count != TALLY_MAX) |=> drop_count == DROP_W'($past(drop_count) + 1'b1));

    p_tally_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_now |=> $stable(drop_count));

endmodule

// File: rtl/bcast_storm_limiter.sv
module bcast_storm_limiter #(
    parameter int LIMIT            = 64,
    parameter int TICKS_PER_WINDOW = 800,
    parameter int DROP_W           = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              storm_off_strap,
    input  logic              win_tick,
    input  logic              frame_start,
    input  logic              frame_bcast,
    output logic              verdict_valid,
    output logic              verdict_drop,
    output logic [DROP_W-1:0] drop_count
);
    logic en_q;
    logic win_close;
    logic drop_now;

    // the strap is taken only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= !storm_off_strap;
    end

    bsl_window_timer #(.TICKS_PER_WINDOW(TICKS_PER_WINDOW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (win_tick),
        .win_close (win_close)
    );

    bsl_run_tracker #(.LIMIT(LIMIT)) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (en_q),
        .frame_start   (frame_start),
        .frame_bcast   (frame_bcast),
        .win_close     (win_close),
        .drop_now      (drop_now),
        .verdict_valid (verdict_valid),
        .verdict_drop  (verdict_drop)
    );

    bsl_drop_tally #(.DROP_W(DROP_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .drop_now   (drop_now),
        .drop_count (drop_count)
    );

    p_off_never_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !verdict_drop);

    p_strap_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(en_q));

    p_drop_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_drop |-> verdict_valid);

endmodule

// File: tb/bcast_storm_limiter_bench.sv
module bcast_storm_limiter_bench;
    localparam int LIMIT  = 64;
    localparam int TICKS  = 8;
    localparam int DROP_W = 4;
    localparam int TMAX   = (1 << DROP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap = 1'b0;
    logic tick = 1'b0;
    logic fs = 1'b0;
    logic fb = 1'b0;
    logic vv;
    logic vd;
    logic [DROP_W-1:0] dc;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    int m_run = 0;
    int m_ticks = 0;
    int m_drops = 0;
    bit m_en = 1;

    always #5 clk = ~clk;

    bcast_storm_limiter #(.LIMIT(LIMIT), .TICKS_PER_WINDOW(TICKS), .DROP_W(DROP_W)) u_bcast_storm_limiter (
        .clk(clk), .rst_n(rst_n), .storm_off_strap(strap), .win_tick(tick),
        .frame_start(fs), .frame_bcast(fb),
        .verdict_valid(vv), .verdict_drop(vd), .drop_count(dc)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit off);
        @(negedge clk);
        rst_n = 1'b0; strap = off; fs = 0; fb = 0; tick = 0;
        repeat (3) @(negedge clk);
        check(vv == 0 && vd == 0, "R9 verdict in reset", {vv, vd}, 0);
        check(dc == 0, "R9 count in reset", dc, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(vv == 0 && dc == 0, "R9 after release", dc, 0);
        m_run = 0; m_ticks = 0; m_drops = 0; m_en = !off;
    endtask

    // one frame, optionally with a coincident tick; checks verdict one edge later
    task automatic frame(input bit bc, input bit with_tick, input string tag);
        bit exp_drop;
        if (with_tick) begin
            m_ticks++;
            if (m_ticks == TICKS) begin m_ticks = 0; m_run = 0; end
        end
        exp_drop = m_en && bc && (m_run >= LIMIT);
        if (m_en) m_run = bc ? ((m_run < LIMIT) ? m_run + 1 : LIMIT) : 0;
        if (exp_drop && m_drops < TMAX) m_drops++;
        @(negedge clk);
        fs = 1; fb = bc; tick = with_tick;
        @(negedge clk);
        fs = 0; fb = 0; tick = 0;
        check(vv == 1, {tag, " R5 valid"}, vv, 1);
        check(vd == exp_drop, {tag, " verdict"}, vd, exp_drop);
        check(dc == m_drops, {tag, " R8 count"}, dc, m_drops);
        @(negedge clk);
        check(vv == 0 && vd == 0, {tag, " R5 pulse ends"}, vv, 0);
    endtask

    task automatic pulse_tick();
        m_ticks++;
        if (m_ticks == TICKS) begin m_ticks = 0; m_run = 0; end
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    task automatic t_run_limit();
        for (int i = 1; i <= LIMIT; i++) frame(1, 0, "R1 pass in run");
        frame(1, 0, "R2 first drop");
        frame(1, 0, "R2 second drop");
        check(m_drops == 2, "R2 model", m_drops, 2);
    endtask

    task automatic t_other_clears();
        frame(0, 0, "R3 non-broadcast in clamp");
        for (int i = 1; i <= LIMIT; i++) frame(1, 0, "R3 pass after clear");
        frame(1, 0, "R3 drop after new run");
    endtask

    task automatic t_window();
        // align the window, then refill the run
        while (m_ticks != 0) pulse_tick();
        for (int i = 1; i <= LIMIT; i++) frame(1, 0, "R4 refill");
        for (int i = 1; i < TICKS; i++) pulse_tick();
        frame(1, 0, "R4 one tick short still drops");
        pulse_tick();
        frame(1, 0, "R4 after window passes");
        // refill, then a broadcast with the closing tick
        for (int i = 1; i < LIMIT; i++) frame(1, 0, "R4 refill again");
        frame(1, 0, "R4 clamp before close");
        while (m_ticks != TICKS - 1) pulse_tick();
        frame(1, 1, "R4 coincident tick passes");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < LIMIT; i++) frame(1, 0, "R2 fill");
        for (int i = 0; i < TMAX + 3; i++) frame(1, 0, "R8 saturate");
        check(dc == TMAX, "R8 saturated", dc, TMAX);
    endtask

    task automatic t_strap_late();
        strap = 1;
        frame(1, 0, "R7 still limiting after strap change");
        strap = 0;
    endtask

    task automatic t_disabled();
        do_reset(1);
        strap = 0;
        for (int i = 0; i < LIMIT + 10; i++) frame(1, 0, "R6 disabled passes");
        check(dc == 0, "R6 no drops", dc, 0);
    endtask

    initial begin
        do_reset(0);
        t_run_limit();
        t_other_clears();
        t_strap_late();
        t_window();
        do_reset(0);
        t_saturate();
        t_disabled();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule